// File: doc/BRIEF.md
# Frame-Aligned Top-of-Frame Pulse Generator

This block produces a periodic top-of-frame (TOF) marker for an output video format and can lock the phase of that marker to a reference video frame of a different format. Two counters set the output frame. A pixel counter covers one line, and a line counter covers one frame. Both advance on a pixel clock-enable strobe. The strobe stands for the selected output clock, so the whole block runs in a single system clock domain. A third counter follows the reference frame. It counts reference lines on active horizontal sync edges and is brought back to line zero by a vertical sync edge. It also starts again by itself once the programmed number of reference lines has passed.

Re-alignment is requested in one of two ways. The first is a 0-to-1 change of an initialization control bit. The second, when the external-init override is enabled, is a rising edge on an external init pulse. Either request is honoured only while alignment is enabled. A request is held until the next alignment boundary. That boundary is every Nth reference frame start, where N is the frame-ratio count, so an output format whose frame rate differs from the reference can still lock on a common period. At the boundary the output pixel counter is cleared and the output line counter is loaded with the signed line offset. This shifts the output frame earlier or later relative to the reference frame.

The block has no streaming data path. All inputs are plain control pins and static configuration fields, and all outputs are plain level signals. For this reason no valid/ready handshake or back-pressure applies.

Top module: `tofgen_frame_aligner`

## Requirements
- R1: While reset is asserted and directly after it, both output counters are at zero, no TOF pulse is active, `tof_o` sits at the inverse of `cfg_tof_pol`, and `tof_oe` equals the inverse of `cfg_tof_hiz`.
- R2: An active TOF pulse drives `tof_o` to the level of `cfg_tof_pol` (1 = active high, 0 = active low). `cfg_tof_hiz` = 1 drives `tof_oe` low at once, and `cfg_tof_hiz` = 0 drives it high.
- R3: In every cycle with `pix_ce` high, the pixel counter steps through 0 to `cfg_ppl`-1. The line counter steps through 0 to `cfg_lpf`-1 each time the pixel counter wraps. Without `pix_ce` both counters hold. The TOF pulse is one cycle long and is active in the cycle after a `pix_ce` cycle in which both counters were zero, so pulses repeat every `cfg_ppl`×`cfg_lpf` enabled cycles.
- R4: Each sync input is active high when its polarity bit (`cfg_hsync_pol`, `cfg_vsync_pol`) is 1 and active low when it is 0. An active vertical edge makes the next active horizontal edge a reference frame start at line 0. With no vertical edge, the horizontal edge after line `cfg_ref_lpf`-1 also starts a new reference frame.
- R5: A reference frame start is an alignment boundary when the frame-ratio counter is zero. That counter counts frame starts modulo `cfg_ratio`, a value of 0 acts as 1, and the first frame start after reset is a boundary.
- R6: While `cfg_align_en` is 1, a 0-to-1 change of `init_ctl` arms one re-alignment. Holding `init_ctl` high arms nothing further.
- R7: While `cfg_align_en` and `cfg_ext_init_en` are both 1, a rising edge on `ext_init` arms one re-alignment. With `cfg_ext_init_en` = 0 the pulse is ignored.
- R8: An armed re-alignment takes effect at the next alignment boundary, whatever the state of `pix_ce`. The pixel counter loads 0, and the line counter loads `cfg_line_offset` (12-bit two's complement, magnitude below `cfg_lpf`) modulo `cfg_lpf`.
- R9: While `cfg_align_en` is 0, `init_ctl` and `ext_init` edges are ignored and any armed request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pix_ce | input | 1 | Output pixel clock enable |
| ref_hsync | input | 1 | Reference horizontal sync |
| ref_vsync | input | 1 | Reference vertical sync |
| cfg_ppl | input | 13 | Output pixels per line |
| cfg_lpf | input | 12 | Output lines per frame |
| cfg_ref_lpf | input | 12 | Reference lines per frame |
| cfg_ratio | input | 13 | Reference frames per alignment period |
| cfg_line_offset | input | 12 | Signed output line offset |
| cfg_hsync_pol | input | 1 | Horizontal sync active level |
| cfg_vsync_pol | input | 1 | Vertical sync active level |
| cfg_tof_pol | input | 1 | TOF active level |
| cfg_tof_hiz | input | 1 | Place TOF output in high impedance |
| cfg_align_en | input | 1 | Alignment mode enable |
| cfg_ext_init_en | input | 1 | Accept external init pulse |
| init_ctl | input | 1 | Initialization control bit |
| ext_init | input | 1 | External init pulse |
| tof_o | output | 1 | Top-of-frame pulse |
| tof_oe | output | 1 | Output enable for the TOF driver |

## Verification
The assertions require the counting formats (`cfg_ppl`, `cfg_lpf`, `cfg_ref_lpf`, `cfg_ratio`) to be non-zero. They must also give at least two enabled cycles per output frame, and they may change only while reset is held. The sync, init and external pulses must each last at least two clock cycles so that every edge is sampled. The stimulus changes format fields only under reset, keeps every offset magnitude below the output line count, and drives each pulse for two or more cycles. The only field it changes while running is the line offset, which affects none of the checked properties.

// File: rtl/tofgen_pkg.sv
package tofgen_pkg;
  localparam int PPL_W   = 13;
  localparam int LINE_W  = 12;
  localparam int RATIO_W = 13;

  // Edge-detected input lanes
  localparam int NUM_SRC = 4;
  typedef enum int {
    SRC_HSYNC = 0,
    SRC_VSYNC = 1,
    SRC_INIT  = 2,
    SRC_EXT   = 3
  } src_e;
endpackage

// File: rtl/tofgen_edge_detect.sv
module tofgen_edge_detect #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic active_high_i,
  output logic rise_o
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic             norm;
  logic [DEPTH-1:0] chain_q;

  // Normalise to active-high before sampling
  assign norm = sig_i ~^ active_high_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[DEPTH-2:0], norm};
  end

  assign rise_o = chain_q[DEPTH-2] & ~chain_q[DEPTH-1];

  a_r4_rise_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tofgen_ref_frame.sv
module tofgen_ref_frame #(
  parameter int LINE_W  = 12,
  parameter int RATIO_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_rise_i,
  input  logic               v_rise_i,
  input  logic [LINE_W-1:0]  cfg_ref_lpf_i,
  input  logic [RATIO_W-1:0] cfg_ratio_i,
  output logic               frame_start_o,
  output logic               boundary_o
);
  logic [LINE_W-1:0]  line_q, line_last;
  logic [RATIO_W-1:0] ratio_q, ratio_last;
  logic               v_pend_q, start_now, fs_q, bnd_q;

  always_comb begin
    line_last  = (cfg_ref_lpf_i == '0) ? '0 : cfg_ref_lpf_i - LINE_W'(1);
    ratio_last = (cfg_ratio_i == '0)   ? '0 : cfg_ratio_i - RATIO_W'(1);
    start_now  = h_rise_i & (v_pend_q | v_rise_i | (line_q == line_last));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= '0;
      ratio_q  <= '0;
      v_pend_q <= 1'b0;
      fs_q     <= 1'b0;
      bnd_q    <= 1'b0;
    end else begin
      if (h_rise_i) begin
        v_pend_q <= 1'b0;
        line_q   <= start_now ? '0 : line_q + LINE_W'(1);
      end else if (v_rise_i) begin
        v_pend_q <= 1'b1;
      end
      fs_q  <= start_now;
      bnd_q <= start_now && (ratio_q == '0);
      if (start_now)
        ratio_q <= (ratio_q == ratio_last) ? '0 : ratio_q + RATIO_W'(1);
    end
  end

  assign frame_start_o = fs_q;
  assign boundary_o    = bnd_q;

  a_r4_ref_line_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ref_lpf_i != '0) |-> (line_q < cfg_ref_lpf_i));
  a_r4_start_follows_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> $past(h_rise_i));
  a_r5_boundary_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_q |-> fs_q);
  a_r5_ratio_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q <= ratio_last);
endmodule

// File: rtl/tofgen_align_ctrl.sv
module tofgen_align_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic align_en_i,
  input  logic ext_en_i,
  input  logic init_rise_i,
  input  logic ext_rise_i,
  input  logic boundary_i,
  output logic load_o
);
  logic armed_q, arm_req;

  assign arm_req = align_en_i & (init_rise_i | (ext_en_i & ext_rise_i));
  assign load_o  = align_en_i & armed_q & boundary_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           armed_q <= 1'b0;
    else if (!align_en_i) armed_q <= 1'b0;
    else                  armed_q <= (armed_q & ~load_o) | arm_req;
  end

  a_r9_disabled_drops_request: assert property (@(posedge clk) disable iff (!rst_n)
    !align_en_i |=> !load_o);
  a_r6_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);
  a_r6_arm_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(init_rise_i | ext_rise_i));
endmodule

// File: rtl/tofgen_out_frame.sv
module tofgen_out_frame #(
  parameter int PPL_W  = 13,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              load_i,
  input  logic [PPL_W-1:0]  cfg_ppl_i,
  input  logic [LINE_W-1:0] cfg_lpf_i,
  input  logic [LINE_W-1:0] cfg_offset_i,
  output logic              tof_pulse_o
);
  logic [PPL_W-1:0]  pix_q, pix_last;
  logic [LINE_W-1:0] line_q, line_last, line_load;
  logic              tof_q, at_origin;

  always_comb begin
    pix_last  = (cfg_ppl_i == '0) ? '0 : cfg_ppl_i - PPL_W'(1);
    line_last = (cfg_lpf_i == '0) ? '0 : cfg_lpf_i - LINE_W'(1);
    // Signed offset folded into [0, lpf) with one add or subtract
    if (cfg_offset_i[LINE_W-1])        line_load = cfg_lpf_i + cfg_offset_i;
    else if (cfg_offset_i >= cfg_lpf_i) line_load = cfg_offset_i - cfg_lpf_i;
    else                                line_load = cfg_offset_i;
    at_origin = (pix_q == '0) && (line_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= '0;
      tof_q  <= 1'b0;
    end else if (load_i) begin
      pix_q  <= '0;
      line_q <= line_load;
      tof_q  <= 1'b0;
    end else if (ce_i) begin
      tof_q <= at_origin;
      if (pix_q == pix_last) begin
        pix_q  <= '0;
        line_q <= (line_q == line_last) ? '0 : line_q + LINE_W'(1);
      end else begin
        pix_q <= pix_q + PPL_W'(1);
      end
    end else begin
      tof_q <= 1'b0;
    end
  end

  assign tof_pulse_o = tof_q;

  a_r3_hold_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_i && !load_i) |=> ($stable(pix_q) && $stable(line_q)));
  a_r3_single_cycle_tof: assert property (@(posedge clk) disable iff (!rst_n)
    tof_q |=> !tof_q);
  a_r3_pix_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ppl_i != '0) |-> (pix_q < cfg_ppl_i));
  a_r8_load_starts_line: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pix_q == '0) && !tof_q);
endmodule

// File: rtl/tofgen_frame_aligner.sv
module tofgen_frame_aligner
  import tofgen_pkg::*;
#(
  parameter int P_PPL_W   = PPL_W,
  parameter int P_LINE_W  = LINE_W,
  parameter int P_RATIO_W = RATIO_W,
  parameter int SYNC_STAGES = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_ce,
  input  logic                 ref_hsync,
  input  logic                 ref_vsync,
  input  logic [P_PPL_W-1:0]   cfg_ppl,
  input  logic [P_LINE_W-1:0]  cfg_lpf,
  input  logic [P_LINE_W-1:0]  cfg_ref_lpf,
  input  logic [P_RATIO_W-1:0] cfg_ratio,
  input  logic [P_LINE_W-1:0]  cfg_line_offset,
  input  logic                 cfg_hsync_pol,
  input  logic                 cfg_vsync_pol,
  input  logic                 cfg_tof_pol,
  input  logic                 cfg_tof_hiz,
  input  logic                 cfg_align_en,
  input  logic                 cfg_ext_init_en,
  input  logic                 init_ctl,
  input  logic                 ext_init,
  output logic                 tof_o,
  output logic                 tof_oe
);
  logic [NUM_SRC-1:0] src_raw, src_pol, src_rise;
  logic frame_start, boundary, load, tof_pulse;

  assign src_raw[SRC_HSYNC] = ref_hsync;
  assign src_raw[SRC_VSYNC] = ref_vsync;
  assign src_raw[SRC_INIT]  = init_ctl;
  assign src_raw[SRC_EXT]   = ext_init;
  assign src_pol[SRC_HSYNC] = cfg_hsync_pol;
  assign src_pol[SRC_VSYNC] = cfg_vsync_pol;
  assign src_pol[SRC_INIT]  = 1'b1;
  assign src_pol[SRC_EXT]   = 1'b1;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_edge
    tofgen_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk           (clk),
      .rst_n         (rst_n),
      .sig_i         (src_raw[g]),
      .active_high_i (src_pol[g]),
      .rise_o        (src_rise[g])
    );
  end

  tofgen_ref_frame #(.LINE_W(P_LINE_W), .RATIO_W(P_RATIO_W)) u_ref (
    .clk           (clk),
    .rst_n         (rst_n),
    .h_rise_i      (src_rise[SRC_HSYNC]),
    .v_rise_i      (src_rise[SRC_VSYNC]),
    .cfg_ref_lpf_i (cfg_ref_lpf),
    .cfg_ratio_i   (cfg_ratio),
    .frame_start_o (frame_start),
    .boundary_o    (boundary)
  );

  tofgen_align_ctrl u_align (
    .clk         (clk),
    .rst_n       (rst_n),
    .align_en_i  (cfg_align_en),
    .ext_en_i    (cfg_ext_init_en),
    .init_rise_i (src_rise[SRC_INIT]),
    .ext_rise_i  (src_rise[SRC_EXT]),
    .boundary_i  (boundary),
    .load_o      (load)
  );

  tofgen_out_frame #(.PPL_W(P_PPL_W), .LINE_W(P_LINE_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_i         (pix_ce),
    .load_i       (load),
    .cfg_ppl_i    (cfg_ppl),
    .cfg_lpf_i    (cfg_lpf),
    .cfg_offset_i (cfg_line_offset),
    .tof_pulse_o  (tof_pulse)
  );

  assign tof_o  = tof_pulse ? cfg_tof_pol : ~cfg_tof_pol;
  assign tof_oe = ~cfg_tof_hiz;

  a_r8_load_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> frame_start);
endmodule

// File: tb/tofgen_frame_aligner_tb.sv
module tofgen_frame_aligner_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    int ppl; int lpf; int off;
    int pol_h; int pol_v; int tof_pol;
    int first; int period;
  } vec_t;

  // Stimulus plus expected cycles to first TOF after enabling, and period
  localparam vec_t VECS [6] = '{
    '{8, 5,  0, 1, 1, 1,  1, 40},
    '{8, 5,  2, 0, 1, 1, 25, 40},
    '{6, 4, -1, 1, 0, 0,  7, 24},
    '{10, 3, 1, 0, 0, 1, 21, 30},
    '{4, 7, -3, 1, 1, 0, 13, 28},
    '{3, 2,  0, 0, 1, 0,  1,  6}
  };

  logic clk = 1'b0;
  logic rst_n, pix_ce, ref_hsync, ref_vsync;
  logic [12:0] cfg_ppl, cfg_ratio;
  logic [11:0] cfg_lpf, cfg_ref_lpf, cfg_line_offset;
  logic cfg_hsync_pol, cfg_vsync_pol, cfg_tof_pol, cfg_tof_hiz;
  logic cfg_align_en, cfg_ext_init_en, init_ctl, ext_init;
  logic tof_o, tof_oe;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tofgen_frame_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
    .ref_hsync(ref_hsync), .ref_vsync(ref_vsync),
    .cfg_ppl(cfg_ppl), .cfg_lpf(cfg_lpf), .cfg_ref_lpf(cfg_ref_lpf),
    .cfg_ratio(cfg_ratio), .cfg_line_offset(cfg_line_offset),
    .cfg_hsync_pol(cfg_hsync_pol), .cfg_vsync_pol(cfg_vsync_pol),
    .cfg_tof_pol(cfg_tof_pol), .cfg_tof_hiz(cfg_tof_hiz),
    .cfg_align_en(cfg_align_en), .cfg_ext_init_en(cfg_ext_init_en),
    .init_ctl(init_ctl), .ext_init(ext_init),
    .tof_o(tof_o), .tof_oe(tof_oe)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_sync();
    ref_hsync = ~cfg_hsync_pol;
    ref_vsync = ~cfg_vsync_pol;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pix_ce = 1'b0;
    init_ctl = 1'b0;
    ext_init = 1'b0;
    idle_sync();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic base_cfg();
    cfg_ppl = 13'd8; cfg_lpf = 12'd5; cfg_line_offset = 12'd2;
    cfg_ref_lpf = 12'd100; cfg_ratio = 13'd1;
    cfg_hsync_pol = 1'b1; cfg_vsync_pol = 1'b1;
    cfg_tof_pol = 1'b1; cfg_tof_hiz = 1'b0;
    cfg_align_en = 1'b1; cfg_ext_init_en = 1'b0;
  endtask

  task automatic hsync_pulse();
    @(negedge clk) ref_hsync = cfg_hsync_pol;
    repeat (2) @(negedge clk);
    ref_hsync = ~cfg_hsync_pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input bit with_v);
    if (with_v) begin
      @(negedge clk) ref_vsync = cfg_vsync_pol;
      repeat (2) @(negedge clk);
      ref_vsync = ~cfg_vsync_pol;
      repeat (2) @(negedge clk);
    end
    hsync_pulse();
  endtask

  task automatic arm_init(input bit keep_high);
    @(negedge clk) init_ctl = 1'b1;
    repeat (3) @(negedge clk);
    if (!keep_high) init_ctl = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ext_pulse();
    @(negedge clk) ext_init = 1'b1;
    repeat (3) @(negedge clk);
    ext_init = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Enable pix_ce and count edges to the first TOF, then to the next one
  task automatic measure(input string tag, input int exp_first, input int exp_period,
                         input bit div2);
    int n;
    bit seen;
    bit phase;
    @(negedge clk);
    pix_ce = 1'b1;
    phase = 1'b1;
    n = 0; seen = 0;
    while (!seen && n < 4000) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (tof_o === cfg_tof_pol) seen = 1;
      if (div2) begin phase = ~phase; pix_ce = phase; end
    end
    check_eq({tag, " first TOF"}, n, exp_first);
    if (exp_period > 0) begin
      n = 0; seen = 0;
      while (!seen && n < 4000) begin
        @(posedge clk); @(negedge clk);
        n++;
        if (tof_o === cfg_tof_pol) seen = 1;
        if (div2) begin phase = ~phase; pix_ce = phase; end
      end
      check_eq("R3 TOF period", n, exp_period);
    end
    pix_ce = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R3 watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    base_cfg();
    rst_n = 1'b0;
    do_reset();

    // R1: reset state, both TOF polarities
    check_eq("R1 tof_o inactive after reset", int'(tof_o), 0);
    check_eq("R1 tof_oe after reset", int'(tof_oe), 1);
    cfg_tof_pol = 1'b0;
    do_reset();
    check_eq("R1 tof_o inactive (active-low) after reset", int'(tof_o), 1);
    cfg_tof_pol = 1'b1;
    // R2: high impedance control
    cfg_tof_hiz = 1'b1;
    #1 check_eq("R2 tof_oe with hiz", int'(tof_oe), 0);
    cfg_tof_hiz = 1'b0;
    #1 check_eq("R2 tof_oe without hiz", int'(tof_oe), 1);

    // Table: R8 offset load, R4 sync polarity, R2 TOF polarity, R3 period
    for (int i = 0; i < 6; i++) begin
      base_cfg();
      cfg_ppl = 13'(VECS[i].ppl);
      cfg_lpf = 12'(VECS[i].lpf);
      cfg_line_offset = VECS[i].off[11:0];
      cfg_hsync_pol = VECS[i].pol_h[0];
      cfg_vsync_pol = VECS[i].pol_v[0];
      cfg_tof_pol = VECS[i].tof_pol[0];
      do_reset();
      arm_init(1'b0);
      send_frame(1'b1);
      measure("R8 R4 R2 table", VECS[i].first, VECS[i].period, 1'b0);
    end

    // R9: alignment disabled ignores init edge
    base_cfg(); do_reset();
    cfg_align_en = 1'b0;
    arm_init(1'b0);
    cfg_align_en = 1'b1;
    send_frame(1'b1);
    measure("R9 init ignored while disabled", 1, 0, 1'b0);

    // R9: request armed then alignment disabled is dropped
    base_cfg(); do_reset();
    arm_init(1'b0);
    cfg_align_en = 1'b0;
    repeat (2) @(negedge clk);
    cfg_align_en = 1'b1;
    send_frame(1'b1);
    measure("R9 armed request dropped", 1, 0, 1'b0);

    // R7: external pulse with override enabled
    base_cfg(); cfg_ext_init_en = 1'b1; do_reset();
    ext_pulse();
    send_frame(1'b1);
    measure("R7 ext pulse aligns", 25, 0, 1'b0);

    // R7: external pulse without override
    base_cfg(); do_reset();
    ext_pulse();
    send_frame(1'b1);
    measure("R7 ext pulse ignored without override", 1, 0, 1'b0);

    // R9: external pulse with alignment disabled
    base_cfg(); cfg_ext_init_en = 1'b1; do_reset();
    cfg_align_en = 1'b0;
    ext_pulse();
    cfg_align_en = 1'b1;
    send_frame(1'b1);
    measure("R9 ext pulse ignored while disabled", 1, 0, 1'b0);

    // R5: ratio 2, second frame is not a boundary, third is
    base_cfg(); cfg_ratio = 13'd2; do_reset();
    send_frame(1'b1);
    arm_init(1'b0);
    send_frame(1'b1);
    measure("R5 no load off boundary", 1, 0, 1'b0);
    send_frame(1'b1);
    measure("R5 load on boundary", 25, 0, 1'b0);

    // R5: ratio 0 behaves as 1
    base_cfg(); cfg_ratio = 13'd0; do_reset();
    send_frame(1'b1);
    arm_init(1'b0);
    send_frame(1'b1);
    measure("R5 ratio zero acts as one", 25, 0, 1'b0);

    // R4: reference frame restarts after cfg_ref_lpf lines without vsync
    base_cfg(); cfg_ref_lpf = 12'd3; do_reset();
    send_frame(1'b1);
    arm_init(1'b0);
    send_frame(1'b0);
    send_frame(1'b0);
    measure("R4 no start before line wrap", 1, 0, 1'b0);
    send_frame(1'b0);
    measure("R4 start on line wrap", 25, 0, 1'b0);

    // R6: held init does not re-arm; a fresh rise does
    base_cfg(); do_reset();
    arm_init(1'b1);
    send_frame(1'b1);
    cfg_line_offset = 12'd0;
    send_frame(1'b1);
    measure("R6 held init gives no reload", 25, 0, 1'b0);
    init_ctl = 1'b0;
    repeat (2) @(negedge clk);
    arm_init(1'b0);
    send_frame(1'b1);
    measure("R6 new init rise reloads", 1, 0, 1'b0);

    // R8: load happens with pix_ce low; R3: halved enable rate
    base_cfg(); cfg_line_offset = 12'd0; do_reset();
    arm_init(1'b0);
    send_frame(1'b1);
    measure("R8 R3 divided enable", 1, 80, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule